// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory with Byte Lanes

The block is a main-memory model that sits behind a 32-bit byte-addressable bus and is organised as four banks interleaved on the low address bits. A requester presents an address, an access size and optionally write data. The two lowest address bits and the size become four active-low byte-lane enables. Address bits [3:2] choose the bank, and the remaining upper bits form the row index that every bank receives. Each bank holds 32-bit words, and byte lane i carries data bits [8i+7:8i] in little-endian order.

Single accesses and four-word line fills both use the same fixed timing: one clock to send the address, then a fifteen-clock bank access. After that, words cross the narrow 32-bit return path at one per clock. All four banks run their slow access together during a line fill, so the fill costs 1+15+4 = 20 clocks instead of 65. A misaligned single access is refused with a one-cycle error pulse and changes no storage.

The controller is a five-state machine. IDLE moves to ADDR when a request is accepted. ADDR always moves to ACCESS. ACCESS moves to XFER after the access latency. XFER moves to DONE after the last word. DONE always moves back to IDLE. A misaligned request keeps the machine in IDLE.

Top module: `lane_ilv_mem`

## Requirements
- R1: `lane_en_n` is a combinational decode of `req_addr[1:0]` and `req_size`, where size 0 = byte, 1 = halfword, 2 = word. A byte at offset k drives only bit k low. A halfword at offset 0 drives 1100 and at offset 2 drives 0011. A word at offset 0 drives 0000.
- R2: A single access is misaligned when it is a halfword at an odd offset, a word at a nonzero offset, or uses size 3. Such an access drives `lane_en_n` = 1111. If it is presented while idle, `err` is high for the one cycle after the sampling edge, `busy` stays low, and no bank is written.
- R3: `req_addr[3:2]` selects the bank for a single access. `req_addr[ADDR_W-1:4]` is the row index inside every bank, so words at different rows of the same bank are independent.
- R4: A single read is accepted at rising edge E0. Its word is on `rd_data` with `rd_valid` high for exactly the cycle after edge E16, and `done` is high for the cycle after edge E17. A single write raises `done` at the same time as a read would.
- R5: A request with `req_line` = 1 is a read fill, and its address bits [3:0] are ignored. It returns the four words of the addressed row in bank order 0,1,2,3 on the cycles after edges E16 to E19, with `rd_valid` high on each. `done` pulses in the cycle after E20.
- R6: A write changes only the bytes whose lane enable is low, in the selected bank and row only, and `rd_valid` never rises during a write.
- R7: `busy` is high from the cycle after acceptance until the machine returns to IDLE. Requests presented while `busy` is high are ignored.
- R8: After reset, `busy`, `rd_valid`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read (single access only) |
| req_line | input | 1 | 1 = four-word line fill (read) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, placed in its byte lanes |
| lane_en_n | output | 4 | Active-low byte-lane enables for the presented request |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read word valid on rd_data |
| rd_data | output | 32 | Returned word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment error pulse |

## Verification
The bench walks every size and offset pair through the lane decoder. A decoder that swaps lane order or accepts odd halfwords would show wrong enables there. It then times reads and line fills edge by edge, so an access counter that is off by one moves the first `rd_valid` away from edge 16 and moves `done` away from edge 17 or 20. Partial writes in bytes 1 and 3 and in the upper halfword catch lane masks that spill into neighbouring bytes. A misaligned write followed by a readback, a write to another row of the same bank, and a write poked in during a busy line fill each reveal storage that should have stayed untouched.

// File: rtl/lane_ilv_pkg.sv
package lane_ilv_pkg;
    localparam int LANES = 4;
    localparam int BANKS = 4;
    localparam int WORD_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER,
        ST_DONE
    } state_e;
endpackage

// File: rtl/lane_ilv_dec.sv
module lane_ilv_dec
    import lane_ilv_pkg::*;
(
    input  logic [1:0]       off,
    input  logic [1:0]       size,
    output logic [LANES-1:0] be_n,
    output logic             misal
);
    always_comb begin
        be_n  = '1;
        misal = 1'b0;
        case (size_e'(size))
            SZ_BYTE: be_n = ~(4'b0001 << off);
            SZ_HALF: begin
                if (off[0]) misal = 1'b1;
                else        be_n  = off[1] ? 4'b0011 : 4'b1100;
            end
            SZ_WORD: begin
                if (off != 2'd0) misal = 1'b1;
                else             be_n  = 4'b0000;
            end
            default: misal = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_ilv_bank.sv
module lane_ilv_bank
    import lane_ilv_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  be_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (!be_n[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/lane_ilv_ctrl.sv
module lane_ilv_ctrl
    import lane_ilv_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LAT   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [1:0]        req_bank,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [LANES-1:0]  dec_be_n,
    input  logic              dec_misal,
    output logic              busy,
    output logic              rd_valid,
    output logic              done,
    output logic              err,
    output logic [BANKS-1:0]  bank_we,
    output logic [1:0]        sel_bank,
    output logic [LANES-1:0]  be_n_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [WORD_W-1:0] wdata_q
);
    localparam int CW = $clog2(LAT + 1);

    state_e        state, state_nx;
    logic [CW-1:0] cnt;
    logic [1:0]    wcnt;
    logic [1:0]    bank_q;
    logic          wr_q, line_q;
    logic          accept;

    assign accept = (state == ST_IDLE) && req_valid && (req_line || !dec_misal);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = ST_ACCESS;
            ST_ACCESS: if (cnt == CW'(LAT - 1)) state_nx = ST_XFER;
            ST_XFER:   if (!line_q || wcnt == 2'd3) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            wcnt    <= '0;
            bank_q  <= '0;
            wr_q    <= 1'b0;
            line_q  <= 1'b0;
            be_n_q  <= '1;
            idx_q   <= '0;
            wdata_q <= '0;
            err     <= 1'b0;
        end else begin
            state <= state_nx;
            err   <= (state == ST_IDLE) && req_valid && !req_line && dec_misal;
            if (accept) begin
                bank_q  <= req_bank;
                wr_q    <= req_write && !req_line;
                line_q  <= req_line;
                be_n_q  <= dec_be_n;
                idx_q   <= req_idx;
                wdata_q <= req_wdata;
            end
            cnt  <= (state == ST_ACCESS) ? cnt + 1'b1 : '0;
            wcnt <= (state == ST_XFER) ? wcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        rd_valid = (state == ST_XFER) && !wr_q;
        done     = (state == ST_DONE);
        sel_bank = line_q ? wcnt : bank_q;
        bank_we  = '0;
        if (state == ST_XFER && wr_q) bank_we[bank_q] = 1'b1;
    end
endmodule

// File: rtl/lane_ilv_mem.sv
module lane_ilv_mem
    import lane_ilv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LAT    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [3:0]        lane_en_n,
    output logic              busy,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              done,
    output logic              err
);
    localparam int IDX_W = ADDR_W - 4;

    logic              misal;
    logic [BANKS-1:0]  bank_we;
    logic [1:0]        sel_bank;
    logic [LANES-1:0]  be_n_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] bank_rd [BANKS];

    lane_ilv_dec i_dec (
        .off   (req_addr[1:0]),
        .size  (req_size),
        .be_n  (lane_en_n),
        .misal (misal)
    );

    lane_ilv_ctrl #(.IDX_W(IDX_W), .LAT(LAT)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_line  (req_line),
        .req_bank  (req_addr[3:2]),
        .req_idx   (req_addr[ADDR_W-1:4]),
        .req_wdata (req_wdata),
        .dec_be_n  (lane_en_n),
        .dec_misal (misal),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .done      (done),
        .err       (err),
        .bank_we   (bank_we),
        .sel_bank  (sel_bank),
        .be_n_q    (be_n_q),
        .idx_q     (idx_q),
        .wdata_q   (wdata_q)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lane_ilv_bank #(.IDX_W(IDX_W)) i_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .be_n  (be_n_q),
            .idx   (idx_q),
            .wdata (wdata_q),
            .rdata (bank_rd[b])
        );
    end

    assign rd_data = bank_rd[sel_bank];
endmodule

// File: rtl/lane_ilv_mem_chk.sv
module lane_ilv_mem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_size,
    input logic [3:0] lane_en_n,
    input logic       busy,
    input logic       rd_valid,
    input logic       done,
    input logic       err
);
    a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        req_size == 2'd0 |-> $countones(~lane_en_n) == 1);

    a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, done, err}));

    a_r5_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r4_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind lane_ilv_mem lane_ilv_mem_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_size  (req_size),
    .lane_en_n (lane_en_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .done      (done),
    .err       (err)
);

// File: tb/test_lane_ilv_mem.sv
module test_lane_ilv_mem;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_line = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    lane_en_n;
    logic          busy, rd_valid, done, err;
    logic [31:0]   rd_data;

    int n_chk = 0, n_err = 0;
    int first_k, done_k, err_k, nval, busy0;
    logic [31:0] words [4];

    always #2 clk = ~clk;

    lane_ilv_mem #(.ADDR_W(AW)) i_lane_ilv_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .lane_en_n(lane_en_n), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err)
    );

    // {offset[1:0], size[1:0], expected be_n[3:0], expected misaligned}
    localparam logic [8:0] VEC [12] = '{
        {2'd0, 2'd0, 4'b1110, 1'b0}, {2'd1, 2'd0, 4'b1101, 1'b0},
        {2'd2, 2'd0, 4'b1011, 1'b0}, {2'd3, 2'd0, 4'b0111, 1'b0},
        {2'd0, 2'd1, 4'b1100, 1'b0}, {2'd2, 2'd1, 4'b0011, 1'b0},
        {2'd1, 2'd1, 4'b1111, 1'b1}, {2'd3, 2'd1, 4'b1111, 1'b1},
        {2'd0, 2'd2, 4'b0000, 1'b0}, {2'd2, 2'd2, 4'b1111, 1'b1},
        {2'd3, 2'd2, 4'b1111, 1'b1}, {2'd0, 2'd3, 4'b1111, 1'b1}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic ln, input logic wr, input logic [1:0] sz,
                         input logic [AW-1:0] a, input logic [31:0] wd,
                         input int poke_c, input logic [AW-1:0] poke_a);
        @(negedge clk);
        req_valid = 1'b1; req_line = ln; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        first_k = -1; done_k = -1; err_k = -1; nval = 0; busy0 = busy;
        for (int c = 0; c < 30; c++) begin
            if (rd_valid) begin
                if (first_k < 0) first_k = c;
                if (nval < 4) words[nval] = rd_data;
                nval++;
            end
            if (done && done_k < 0) done_k = c;
            if (err && err_k < 0) err_k = c;
            if (c == poke_c) begin
                req_valid = 1'b1; req_line = 1'b0; req_write = 1'b1;
                req_size = 2'd2; req_addr = poke_a; req_wdata = 32'h0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic rd_word(input string rq, input logic [AW-1:0] a, input logic [31:0] exp);
        issue(1'b0, 1'b0, 2'd2, a, 32'h0, -1, '0);
        chk({rq, " data"}, words[0], exp);
        chk({rq, " first"}, first_k, 16);
        chk({rq, " done"}, done_k, 17);
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset outputs", {busy, rd_valid, done, err}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle after reset", {busy, rd_valid, done, err}, 4'b0000);

        // R1 / R2 lane decode table
        for (int i = 0; i < 12; i++) begin
            req_addr = {6'd0, VEC[i][8:7]};
            req_size = VEC[i][6:5];
            #1;
            chk($sformatf("R1 R2 lanes vec %0d", i), lane_en_n, VEC[i][4:1]);
        end

        // full-word writes to row 2 of each bank (R3, R6)
        for (int b = 0; b < 4; b++) begin
            issue(1'b0, 1'b1, 2'd2, AW'(8'h20 | (b << 2)), 32'h1111_1111 * (b + 1), -1, '0);
            chk("R6 no rd_valid on write", nval, 0);
            chk("R4 write done timing", done_k, 17);
        end
        chk("R7 busy after accept", busy0, 1);

        // R5 line fill, low nibble ignored
        issue(1'b1, 1'b0, 2'd2, 8'h2A, 32'h0, -1, '0);
        chk("R5 word count", nval, 4);
        chk("R5 first word edge", first_k, 16);
        chk("R5 done edge", done_k, 20);
        for (int b = 0; b < 4; b++)
            chk($sformatf("R5 bank order word %0d", b), words[b], 32'h1111_1111 * (b + 1));

        // R6 partial writes
        issue(1'b0, 1'b1, 2'd0, 8'h29, 32'h0000_AB00, -1, '0);
        rd_word("R6 byte lane 1", 8'h28, 32'h3333_AB33);
        issue(1'b0, 1'b1, 2'd1, 8'h2E, 32'hBEEF_0000, -1, '0);
        rd_word("R6 upper half", 8'h2C, 32'hBEEF_4444);
        issue(1'b0, 1'b1, 2'd0, 8'h27, 32'h5A00_0000, -1, '0);
        rd_word("R6 byte lane 3", 8'h24, 32'h5A22_2222);

        // R2 misaligned write refused
        issue(1'b0, 1'b1, 2'd2, 8'h21, 32'hFFFF_FFFF, -1, '0);
        chk("R2 err cycle", err_k, 0);
        chk("R2 stays idle", busy0, 0);
        chk("R2 no done", done_k, -1);
        rd_word("R2 no write", 8'h20, 32'h1111_1111);
        issue(1'b0, 1'b1, 2'd1, 8'h23, 32'hFFFF_FFFF, -1, '0);
        chk("R2 odd half err", err_k, 0);
        rd_word("R2 odd half no write", 8'h20, 32'h1111_1111);

        // R3 rows are independent
        issue(1'b0, 1'b1, 2'd2, 8'h50, 32'hDEAD_BEEF, -1, '0);
        rd_word("R3 other row untouched", 8'h20, 32'h1111_1111);
        rd_word("R3 new row", 8'h50, 32'hDEAD_BEEF);

        // R7 request during busy ignored
        issue(1'b1, 1'b0, 2'd2, 8'h20, 32'h0, 5, 8'h24);
        chk("R7 fill unaffected", words[1], 32'h5A22_2222);
        rd_word("R7 poke ignored", 8'h24, 32'h5A22_2222);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule